// File: doc/BRIEF.md
# Indirectly Programmed 64-Line Interrupt Controller

This block gathers 64 interrupt request lines, numbered 0 to 63. It presents one of them at a time to a host as a request with a vector. The host reaches the per-line enable mask and the per-line sensing mode through two registers only. It first loads a selector into a small address register. It then reads or writes a shared 64-bit data window that the selector steers onto one of the two internal registers. Selector 0x40 opens the mask, where a 1 disables a line. Selector 0x50 opens the sensing mode, where a 1 means level and a 0 means rising edge.

Every line is synchronized before use. A line in edge mode latches a pending flag on each rising edge, and it does so even while the line is masked. A line in level mode is pending for as long as its synchronized input is high. When no request is outstanding, the lowest-numbered line that is pending, enabled and not in service is accepted and marked in service. It is then presented on the request output. The vector is 0x800 + 1024 × hose index + 16 × line.

The presentation holds until the host writes that line number to the end-of-interrupt port. This write is the only acknowledgement and the only back-pressure: no other line is presented while one is outstanding. Lines 7 to 22 carry a 16-line legacy bus, so legacy request k is line k+7 and its sensing bit is bit k+7. All pins are plain control and status pins, because no data stream crosses the block.

Top module: `irqc_indirect`

## Requirements
- R1: The selector register reads back, on `sel_q`, the last value written with `sel_wr`, from the cycle after the write.
- R2: With selector 0x40, `dat_rdata` shows the mask and a `dat_wr` replaces it. A 1 in bit n keeps line n from ever being accepted.
- R3: After reset the mask reads all ones, the mode register reads zero, and `irq_req` is low with no pending or in-service line.
- R4: With selector 0x50, `dat_rdata` shows the mode register and a `dat_wr` replaces it. Bit n = 1 makes line n level-sensitive and bit n = 0 makes it edge-sensitive.
- R5: With any selector other than 0x40 or 0x50, `dat_rdata` reads zero and `dat_wr` changes neither internal register.
- R6: An edge-mode line latches a pending request on a rising edge of its synchronized input, even while masked. Accepting the line clears that latch, so a single edge is presented once.
- R7: A level-mode line is pending only while its input is high. A line that has fallen is not presented again after its end-of-interrupt.
- R8: Among eligible lines, the lowest-numbered one is accepted first.
- R9: `irq_req` and `irq_vec` hold from acceptance until an `eoi_wr` carrying that line's number. No other line is presented meanwhile.
- R10: An `eoi_wr` naming a line that is not in service has no effect.
- R11: While `irq_req` is high, `irq_vec` = 0x800 + 1024 × `hose_idx` + 16 × line. While `irq_req` is low, `irq_vec` reads zero.
- R12: Legacy request k (0 to 15) is line k+7, and its sensing is chosen by mode bit k+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Raw interrupt lines, asynchronous |
| hose_idx | input | 2 | Hose index used in the vector base |
| sel_wr | input | 1 | Load the selector register |
| sel_wdata | input | 8 | Selector value |
| sel_q | output | 8 | Selector read-back |
| dat_wr | input | 1 | Write the selected 64-bit register |
| dat_wdata | input | 64 | Write data for the data window |
| dat_rdata | output | 64 | Selected register, or zero for an unknown selector |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 6 | Line number being retired |
| irq_req | output | 1 | Interrupt request to the host |
| irq_vec | output | 16 | Vector of the presented line |

## Verification
Single edge pulses on a masked line, followed by an unmask, show that edges are latched regardless of the mask and are consumed on acceptance. Three lines pulsed in the same cycle separate lowest-number priority from arrival order, and an end-of-interrupt for a wrong line distinguishes per-line retirement from a blanket clear. A held level input on a legacy line must be presented again after each retirement and must stop once the input drops. An edge raised on a lower line while that level line is in service shows that the outstanding request is not pre-empted. The bench model follows every cycle of these patterns, including the synchronizer latency, so off-by-one-cycle errors also stand out.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SEL_W      = 8;
  localparam logic [SEL_W-1:0] SEL_MASK = 8'h40;
  localparam logic [SEL_W-1:0] SEL_MODE = 8'h50;
  localparam int VEC_BASE   = 'h800;
  localparam int HOSE_SHIFT = 10;
  localparam int LINE_SHIFT = 4;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int N      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= raw;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else prev <= pipe[STAGES-1];
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  input  logic             dat_wr,
  input  logic [N-1:0]     dat_wdata,
  output logic [N-1:0]     dat_rdata,
  output logic [N-1:0]     mask_q,
  output logic [N-1:0]     mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= '1;
      mode_q <= '0;
    end else begin
      if (dat_wr && sel_q == SEL_MASK) mask_q <= dat_wdata;
      if (dat_wr && sel_q == SEL_MODE) mode_q <= dat_wdata;
      if (sel_wr) sel_q <= sel_wdata;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_MASK: dat_rdata = mask_q;
      SEL_MODE: dat_rdata = mode_q;
      default:  dat_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 64,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_indirect.sv
module irqc_indirect
  import irqc_pkg::*;
#(
  parameter int NLINES      = 64,
  parameter int HOSE_W      = 2,
  parameter int VEC_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [HOSE_W-1:0] hose_idx,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wdata,
  output logic [SEL_W-1:0]  sel_q,
  input  logic              dat_wr,
  input  logic [NLINES-1:0] dat_wdata,
  output logic [NLINES-1:0] dat_rdata,
  input  logic              eoi_wr,
  input  logic [LW-1:0]     eoi_line,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NLINES-1:0] sync_lvl, sync_rise;
  logic [NLINES-1:0] mask_q, mode_q;
  logic [NLINES-1:0] edge_pend, inserv, pending, cand;
  logic [NLINES-1:0] accept_bit;
  logic              cand_any, accept, eoi_hit;
  logic [LW-1:0]     win_idx;
  logic              cur_valid;
  logic [LW-1:0]     cur_line;

  irqc_sync #(.N(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .level(sync_lvl), .rise(sync_rise)
  );

  irqc_regs #(.N(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .sel_q(sel_q), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .mask_q(mask_q), .mode_q(mode_q)
  );

  assign pending = edge_pend | (sync_lvl & mode_q);
  assign cand    = pending & ~mask_q & ~inserv;

  irqc_prio #(.N(NLINES)) u_prio (.cand(cand), .any(cand_any), .idx(win_idx));

  assign accept     = !cur_valid && cand_any;
  assign accept_bit = accept ? (NLINES'(1) << win_idx) : '0;
  assign eoi_hit    = eoi_wr && inserv[eoi_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_pend <= '0;
      inserv    <= '0;
      cur_valid <= 1'b0;
      cur_line  <= '0;
    end else begin
      edge_pend <= (edge_pend & ~accept_bit) | (sync_rise & ~mode_q);
      if (eoi_hit) begin
        inserv[eoi_line] <= 1'b0;
        if (cur_valid && cur_line == eoi_line) cur_valid <= 1'b0;
      end else if (accept) begin
        inserv    <= inserv | accept_bit;
        cur_valid <= 1'b1;
        cur_line  <= win_idx;
      end
    end
  end

  assign irq_req = cur_valid;
  assign irq_vec = cur_valid
    ? VEC_W'(VEC_BASE) + (VEC_W'(hose_idx) << HOSE_SHIFT) + (VEC_W'(cur_line) << LINE_SHIFT)
    : '0;
endmodule

// File: rtl/irqc_indirect_chk.sv
module irqc_indirect_chk
  import irqc_pkg::*;
#(
  parameter int NLINES = 64,
  parameter int HOSE_W = 2,
  parameter int VEC_W  = 16,
  localparam int LW = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HOSE_W-1:0] hose_idx,
  input logic              sel_wr,
  input logic [SEL_W-1:0]  sel_wdata,
  input logic [SEL_W-1:0]  sel_q,
  input logic              dat_wr,
  input logic [NLINES-1:0] dat_wdata,
  input logic [NLINES-1:0] dat_rdata,
  input logic              eoi_wr,
  input logic [LW-1:0]     eoi_line,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              cur_valid,
  input logic [LW-1:0]     cur_line,
  input logic [NLINES-1:0] mask_q
);
  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(sel_wdata)); // R1
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !sel_wr && sel_q == SEL_MASK) |=> dat_rdata == $past(dat_wdata)); // R2
  AST_ACCEPT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_valid) |-> ((($past(mask_q) >> cur_line) & NLINES'(1)) == '0)); // R2
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !sel_wr && sel_q == SEL_MODE) |=> dat_rdata == $past(dat_wdata)); // R4
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != SEL_MASK && sel_q != SEL_MODE) |-> dat_rdata == '0); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !eoi_wr) |=> irq_req && $stable(cur_line)); // R9
  AST_OTHER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && eoi_wr && eoi_line != cur_line) |=> irq_req && $stable(cur_line)); // R10
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == '0); // R11
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[LINE_SHIFT-1:0] == '0 && irq_vec >= VEC_W'(VEC_BASE))); // R11
endmodule

bind irqc_indirect irqc_indirect_chk #(.NLINES(NLINES), .HOSE_W(HOSE_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_irqc_indirect.sv
module sim_irqc_indirect;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic [1:0]  hose_idx = 2'd1;
  logic        sel_wr = 0, dat_wr = 0, eoi_wr = 0;
  logic [7:0]  sel_wdata = '0;
  logic [63:0] dat_wdata = '0;
  logic [5:0]  eoi_line = '0;
  logic [7:0]  sel_q;
  logic [63:0] dat_rdata;
  logic        irq_req;
  logic [15:0] irq_vec;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  irqc_indirect u0 (.*);

  // Behavioural reference state
  logic [63:0] m_mask = '1, m_mode = '0, m_edge = '0, m_ins = '0;
  logic [63:0] h0 = '0, h1 = '0, h2 = '0; // input samples, newest first
  logic [7:0]  m_sel = '0;
  bit          m_cv = 0;
  int          m_cl = 0;

  always @(posedge clk) begin : model
    logic [63:0] pend, cand, rise;
    int win;
    if (!rst_n) begin
      m_mask = '1; m_mode = '0; m_edge = '0; m_ins = '0;
      h0 = '0; h1 = '0; h2 = '0; m_sel = '0; m_cv = 0; m_cl = 0;
    end else begin
      pend = m_edge | (h1 & m_mode);
      cand = pend & ~m_mask & ~m_ins;
      rise = h1 & ~h2 & ~m_mode;
      win = -1;
      for (int i = 63; i >= 0; i--) if (cand[i]) win = i;
      if (eoi_wr && m_ins[eoi_line]) begin
        m_ins[eoi_line] = 1'b0;
        if (m_cv && m_cl == int'(eoi_line)) m_cv = 0;
      end else if (!m_cv && win >= 0) begin
        m_cv = 1; m_cl = win; m_ins[win] = 1'b1; m_edge[win] = 1'b0;
      end
      m_edge = m_edge | rise;
      if (dat_wr && m_sel == 8'h40) m_mask = dat_wdata;
      if (dat_wr && m_sel == 8'h50) m_mode = dat_wdata;
      if (sel_wr) m_sel = sel_wdata;
      h2 = h1; h1 = h0; h0 = irq_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input int line);
    return 16'h800 + 16'(hose_idx) * 16'd1024 + 16'(line) * 16'd16;
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_req == m_cv, "R9 req vs model", 64'(irq_req), 64'(m_cv));
      chk(irq_vec == (m_cv ? vec_of(m_cl) : 16'h0), "R11 vec vs model", 64'(irq_vec),
          64'(m_cv ? vec_of(m_cl) : 16'h0));
      chk(sel_q == m_sel, "R1 sel vs model", 64'(sel_q), 64'(m_sel));
      chk(dat_rdata == (m_sel == 8'h40 ? m_mask : m_sel == 8'h50 ? m_mode : 64'h0),
          "R2 rdata vs model", dat_rdata,
          (m_sel == 8'h40 ? m_mask : m_sel == 8'h50 ? m_mode : 64'h0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr_sel(input logic [7:0] v); sel_wr = 1; sel_wdata = v; step(1); sel_wr = 0; endtask
  task automatic wr_dat(input logic [63:0] v); dat_wr = 1; dat_wdata = v; step(1); dat_wr = 0; endtask
  task automatic eoi(input int l); eoi_wr = 1; eoi_line = 6'(l); step(1); eoi_wr = 0; endtask
  task automatic wait_req(input int n);
    for (int i = 0; i < n && !irq_req; i++) step(1);
  endtask

  localparam logic [63:0] B2 = 64'd1 << 2, B3 = 64'd1 << 3, B10 = 64'd1 << 10;
  localparam logic [63:0] B17 = 64'd1 << 17, B20 = 64'd1 << 20, B30 = 64'd1 << 30, B40 = 64'd1 << 40;

  initial begin
    step(3); rst_n = 1; step(1);
    chk(irq_req == 0, "R3 no request after reset", 64'(irq_req), 0);
    wr_sel(8'h40);
    chk(sel_q == 8'h40, "R1 selector readback", 64'(sel_q), 64'h40);
    chk(dat_rdata == '1, "R3 mask all ones after reset", dat_rdata, '1);
    // R5: unknown selector
    wr_sel(8'h33);
    chk(dat_rdata == 0, "R5 unknown selector reads zero", dat_rdata, 0);
    wr_dat(64'hFFFF_0000_1234_0000);
    chk(dat_rdata == 0, "R5 still zero after write", dat_rdata, 0);
    wr_sel(8'h40);
    chk(dat_rdata == '1, "R5 mask untouched", dat_rdata, '1);
    wr_sel(8'h50);
    chk(dat_rdata == 0, "R3 mode zero after reset", dat_rdata, 0);
    wr_dat(B17 | B30);
    chk(dat_rdata == (B17 | B30), "R4 mode readback", dat_rdata, B17 | B30);
    // R6: edge on masked line is latched
    irq_in[3] = 1; step(2); irq_in[3] = 0; step(6);
    chk(irq_req == 0, "R6 masked edge not presented", 64'(irq_req), 0);
    wr_sel(8'h40); wr_dat(~B3);
    chk(dat_rdata == ~B3, "R2 mask readback", dat_rdata, ~B3);
    wait_req(10);
    chk(irq_req == 1, "R6 latched edge presented on unmask", 64'(irq_req), 1);
    chk(irq_vec == 16'hC30, "R11 vector line 3 hose 1", 64'(irq_vec), 64'hC30);
    eoi(5); step(2);
    chk(irq_req == 1 && irq_vec == 16'hC30, "R10 eoi of idle line ignored", 64'(irq_vec), 64'hC30);
    eoi(3);
    chk(irq_req == 0, "R9 request drops after eoi", 64'(irq_req), 0);
    step(6);
    chk(irq_req == 0, "R6 single edge presented once", 64'(irq_req), 0);
    // R8: priority
    wr_dat(~(B2 | B3 | B10 | B17 | B20 | B40));
    irq_in[40] = 1; irq_in[20] = 1; irq_in[10] = 1; step(2);
    irq_in[40] = 0; irq_in[20] = 0; irq_in[10] = 0;
    wait_req(10);
    chk(irq_vec == 16'hCA0, "R8 lowest line 10 first", 64'(irq_vec), 64'hCA0);
    step(3);
    chk(irq_vec == 16'hCA0, "R9 held until eoi", 64'(irq_vec), 64'hCA0);
    eoi(10); wait_req(10);
    chk(irq_vec == 16'hD40, "R8 line 20 second", 64'(irq_vec), 64'hD40);
    eoi(20); wait_req(10);
    chk(irq_vec == 16'hE80, "R8 line 40 third", 64'(irq_vec), 64'hE80);
    eoi(40); step(1);
    // R12 / R7: legacy level line 10 -> line 17
    irq_in[17] = 1; wait_req(10);
    chk(irq_vec == 16'hD10, "R12 legacy 10 level on line 17", 64'(irq_vec), 64'hD10);
    irq_in[2] = 1; step(6);
    chk(irq_vec == 16'hD10, "R9 no preemption by line 2", 64'(irq_vec), 64'hD10);
    eoi(17); wait_req(10);
    chk(irq_vec == 16'hC20, "R8 line 2 before level 17", 64'(irq_vec), 64'hC20);
    irq_in[2] = 0;
    eoi(2); wait_req(10);
    chk(irq_vec == 16'hD10, "R7 level re-presented while high", 64'(irq_vec), 64'hD10);
    irq_in[17] = 0; step(4);
    eoi(17); step(8);
    chk(irq_req == 0, "R7 fallen level not re-presented", 64'(irq_req), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule